// File: doc/BRIEF.md
# USB Endpoint Handshake Register Unit

This block is the meeting point between a USB protocol engine and the firmware that serves three endpoints: endpoint 0 is the control endpoint, endpoints 1 and 2 carry data. The protocol engine reports one event per cycle. An event is a SETUP received, an OUT received, an IN packet acknowledged by the host, or a STALL handshake sent. The block turns each event into status bits, a packet length, a flipped data toggle and a per-endpoint interrupt flag. Firmware writes per-endpoint control words. These words arm transmission, force a stall, mark the end of the data phase and enable the endpoint. Firmware never clears a status bit directly. It writes a one to a matching acknowledge bit instead.

The control endpoint also follows the stage of the current control transfer in a small state machine. The machine moves through the setup, data and status phases of write, read and no-data transfers. Firmware reads every register through one combinational read port addressed by group and endpoint index. All writes go through one write port.

Top module: `usb_ep_handshake`

## Requirements
- R1: The address is {group[3:2], index[1:0]}. Group 0 holds the status word of endpoint `index`, group 1 its control word, group 2 its byte count. Group 3 index 0 is the interrupt flag word (bit n = endpoint n) and group 3 index 1 is the write-only interrupt acknowledge. Index 3 in groups 0 to 2, group 3 indices 1 to 3, and every bit without a function read as zero.
- R2: A SETUP event (kind 0) on enabled endpoint 0 does the following: it sets the setup-received status bit (bit 2), loads the byte count, clears force-stall and data-end, and moves the stage to setup response (1) from any stage. SETUP on endpoints 1 and 2 is ignored.
- R3: An OUT event (kind 1) on an enabled endpoint whose force-stall is clear sets the OUT-received status bit (bit 1) and loads the 5-bit byte count from the event length.
- R4: An IN-acknowledged event (kind 2) is accepted only on an enabled endpoint with tx-ready (control bit 4) set and force-stall clear. It clears tx-ready and sets tx-done (status bit 0).
- R5: The data toggle (status bit 4) inverts on every accepted SETUP, OUT or IN event and on nothing else.
- R6: A STALL event (kind 3) on an enabled endpoint with force-stall (control bit 5) set sets stall-sent (status bit 3). Writes to status-word addresses have no effect.
- R7: Writing a one to control bits 0, 1, 2 or 3 clears tx-done, OUT-received, setup-received or stall-sent respectively. Control bits 7..4 (enable, data-end, force-stall, tx-ready) are loaded by the write and read back; bits 3..0 read zero. A status set or tx-ready clear caused by an event in the same cycle wins over the write.
- R8: Every accepted SETUP, OUT or IN event sets its endpoint's interrupt flag. Writing a one to bit n of the acknowledge word clears flag n, and a same-cycle set wins. The irq output is high exactly when any flag is set.
- R9: An endpoint with the enable bit (control bit 7) clear ignores every event: no status, count, toggle or interrupt change.
- R10: The stage encoding is idle 0, setup response 1, write data 2, read data 3, write status 4, read status 5, no-data status 6. From 1, OUT goes to 2, IN goes to 3, and otherwise data-end set goes to 6. In 2, OUT stays and otherwise data-end goes to 4. In 3, IN stays and otherwise data-end goes to 5. 4 and 6 return to 0 on IN, and 5 returns to 0 on OUT. Only accepted endpoint-0 events count.
- R11: After reset every register, flag and count is zero, the stage is idle and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | 1 | Protocol event present this cycle |
| ev_ep | input | 2 | Endpoint of the event (3 matches none) |
| ev_kind | input | 2 | 0 SETUP, 1 OUT, 2 IN acknowledged, 3 STALL sent |
| ev_len | input | 5 | Packet byte count of SETUP/OUT |
| wr_en | input | 1 | Firmware write strobe |
| wr_addr | input | 4 | Firmware write address |
| wr_data | input | 8 | Firmware write data |
| rd_addr | input | 4 | Firmware read address |
| rd_data | output | 8 | Read data (combinational) |
| irq | output | 1 | OR of the endpoint interrupt flags |
| stage | output | 3 | Control-transfer stage of endpoint 0 |

## Verification
Directed sequences walk the control endpoint through write, read and no-data transfers, so that each stage transition is observed through the stage port. Further directed cases place an event and a firmware write in the same cycle. These show whether events take priority over acknowledge clears and control-word loads. Single events aimed at disabled or stalled endpoints, and IN completions without tx-ready, show whether acceptance is gated correctly rather than merely recorded. A long seeded random mix of events, control writes, acknowledge writes and stray writes is then compared after every cycle against a bench model of all readable state. This catches ordering faults that the directed cases do not reach.

// File: rtl/usb_hs_pkg.sv
package usb_hs_pkg;

  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    EV_SETUP = 2'd0,
    EV_OUT   = 2'd1,
    EV_IN    = 2'd2,
    EV_STALL = 2'd3
  } ev_kind_t;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_WDATA  = 3'd2,
    ST_RDATA  = 3'd3,
    ST_WSTAT  = 3'd4,
    ST_RSTAT  = 3'd5,
    ST_NDSTAT = 3'd6
  } stage_t;

  // Next control-transfer stage from accepted endpoint-0 events and data-end.
  function automatic stage_t next_stage(stage_t cur, logic setup, logic out_ev,
                                        logic in_ev, logic dend);
    stage_t nxt;
    nxt = cur;
    if (setup) begin
      nxt = ST_SETUP;
    end else begin
      case (cur)
        ST_SETUP:  if (out_ev) nxt = ST_WDATA;
                   else if (in_ev) nxt = ST_RDATA;
                   else if (dend) nxt = ST_NDSTAT;
        ST_WDATA:  if (!out_ev && dend) nxt = ST_WSTAT;
        ST_RDATA:  if (!in_ev && dend) nxt = ST_RSTAT;
        ST_WSTAT:  if (in_ev) nxt = ST_IDLE;
        ST_RSTAT:  if (out_ev) nxt = ST_IDLE;
        ST_NDSTAT: if (in_ev) nxt = ST_IDLE;
        default:   nxt = cur;
      endcase
    end
    return nxt;
  endfunction

  // Status word layout: bit0 tx-done, 1 OUT, 2 SETUP, 3 stall-sent, 4 toggle.
  function automatic logic [REG_W-1:0] pack_status(logic txd, logic rxo, logic rxs,
                                                   logic sts, logic tog);
    return {3'b000, tog, sts, rxs, rxo, txd};
  endfunction

  // Control word readback: bits 7..4 persistent, acknowledge bits read zero.
  function automatic logic [REG_W-1:0] pack_control(logic en, logic dend, logic fst,
                                                    logic txr);
    return {en, dend, fst, txr, 4'b0000};
  endfunction

endpackage

// File: rtl/usb_ep_regs.sv
module usb_ep_regs
  import usb_hs_pkg::*;
#(
  parameter bit IS_CTRL = 1'b0,
  parameter int CNT_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_hit,
  input  logic [1:0]       ev_kind,
  input  logic [CNT_W-1:0] ev_len,
  input  logic             car_we,
  input  logic [REG_W-1:0] car_wdata,
  output logic [REG_W-1:0] csr_rd,
  output logic [REG_W-1:0] car_rd,
  output logic [REG_W-1:0] cnt_rd,
  output logic             acc_setup,
  output logic             acc_out,
  output logic             acc_in,
  output logic             acc_xfer,
  output logic             dend_o,
  output logic             tog_o,
  output logic             en_o
);

  logic tx_done, rx_out, rx_setup, stall_sent, toggle;
  logic tx_ready, fstall, dend, enable;
  logic [CNT_W-1:0] cnt;
  logic acc_stall;

  assign acc_setup = IS_CTRL && ev_hit && (ev_kind == EV_SETUP) && enable;
  assign acc_out   = ev_hit && (ev_kind == EV_OUT) && enable && !fstall;
  assign acc_in    = ev_hit && (ev_kind == EV_IN) && enable && !fstall && tx_ready;
  assign acc_stall = ev_hit && (ev_kind == EV_STALL) && enable && fstall;
  assign acc_xfer  = acc_setup || acc_out || acc_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_done    <= 1'b0;
      rx_out     <= 1'b0;
      rx_setup   <= 1'b0;
      stall_sent <= 1'b0;
      toggle     <= 1'b0;
      tx_ready   <= 1'b0;
      fstall     <= 1'b0;
      dend       <= 1'b0;
      enable     <= 1'b0;
      cnt        <= '0;
    end else begin
      if (car_we) begin
        if (car_wdata[0]) tx_done    <= 1'b0;
        if (car_wdata[1]) rx_out     <= 1'b0;
        if (car_wdata[2]) rx_setup   <= 1'b0;
        if (car_wdata[3]) stall_sent <= 1'b0;
        tx_ready <= car_wdata[4];
        fstall   <= car_wdata[5];
        dend     <= car_wdata[6];
        enable   <= car_wdata[7];
      end
      if (acc_setup) begin
        rx_setup <= 1'b1;
        cnt      <= ev_len;
        fstall   <= 1'b0;
        dend     <= 1'b0;
      end
      if (acc_out) begin
        rx_out <= 1'b1;
        cnt    <= ev_len;
      end
      if (acc_in) begin
        tx_ready <= 1'b0;
        tx_done  <= 1'b1;
      end
      if (acc_stall) stall_sent <= 1'b1;
      if (acc_xfer)  toggle     <= ~toggle;
    end
  end

  assign csr_rd = pack_status(tx_done, rx_out, rx_setup, stall_sent, toggle);
  assign car_rd = pack_control(enable, dend, fstall, tx_ready);
  assign cnt_rd = {{(REG_W-CNT_W){1'b0}}, cnt};
  assign dend_o = dend;
  assign tog_o  = toggle;
  assign en_o   = enable;

endmodule

// File: rtl/usb_ctl_stage.sv
module usb_ctl_stage
  import usb_hs_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   acc_setup,
  input  logic   acc_out,
  input  logic   acc_in,
  input  logic   dend,
  output stage_t stage
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage <= ST_IDLE;
    else        stage <= next_stage(stage, acc_setup, acc_out, acc_in, dend);
  end

endmodule

// File: rtl/usb_ep_handshake.sv
module usb_ep_handshake
  import usb_hs_pkg::*;
#(
  parameter int NUM_EP = 3,
  parameter int CNT_W  = 5,
  localparam int EP_W   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  localparam int ADDR_W = EP_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [EP_W-1:0]   ev_ep,
  input  logic [1:0]        ev_kind,
  input  logic [CNT_W-1:0]  ev_len,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic              irq,
  output logic [2:0]        stage
);

  localparam logic [1:0] GRP_CSR = 2'd0;
  localparam logic [1:0] GRP_CAR = 2'd1;
  localparam logic [1:0] GRP_CNT = 2'd2;
  localparam logic [1:0] GRP_INT = 2'd3;

  logic [REG_W-1:0] csr_rd [NUM_EP];
  logic [REG_W-1:0] car_rd [NUM_EP];
  logic [REG_W-1:0] cnt_rd [NUM_EP];
  logic [NUM_EP-1:0] acc_setup_v, acc_out_v, acc_in_v, acc_xfer;
  logic [NUM_EP-1:0] dend_v, tog_vec, en_vec, int_flags;
  logic acc_setup0;
  logic int_ack_we;
  stage_t stage_q;

  wire [1:0]      wr_grp = wr_addr[ADDR_W-1:ADDR_W-2];
  wire [EP_W-1:0] wr_idx = wr_addr[EP_W-1:0];
  wire [1:0]      rd_grp = rd_addr[ADDR_W-1:ADDR_W-2];
  wire [EP_W-1:0] rd_idx = rd_addr[EP_W-1:0];

  assign int_ack_we = wr_en && (wr_grp == GRP_INT) && (wr_idx == EP_W'(1));

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    usb_ep_regs #(
      .IS_CTRL (i == 0),
      .CNT_W   (CNT_W)
    ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev_hit    (ev_valid && (ev_ep == EP_W'(i))),
      .ev_kind   (ev_kind),
      .ev_len    (ev_len),
      .car_we    (wr_en && (wr_grp == GRP_CAR) && (wr_idx == EP_W'(i))),
      .car_wdata (wr_data),
      .csr_rd    (csr_rd[i]),
      .car_rd    (car_rd[i]),
      .cnt_rd    (cnt_rd[i]),
      .acc_setup (acc_setup_v[i]),
      .acc_out   (acc_out_v[i]),
      .acc_in    (acc_in_v[i]),
      .acc_xfer  (acc_xfer[i]),
      .dend_o    (dend_v[i]),
      .tog_o     (tog_vec[i]),
      .en_o      (en_vec[i])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          int_flags[i] <= 1'b0;
      else if (acc_xfer[i])                int_flags[i] <= 1'b1;
      else if (int_ack_we && wr_data[i])   int_flags[i] <= 1'b0;
    end
  end

  assign acc_setup0 = acc_setup_v[0];

  usb_ctl_stage u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_setup (acc_setup0),
    .acc_out   (acc_out_v[0]),
    .acc_in    (acc_in_v[0]),
    .dend      (dend_v[0]),
    .stage     (stage_q)
  );

  always_comb begin
    rd_data = '0;
    if (rd_grp == GRP_INT) begin
      if (rd_idx == '0) rd_data = REG_W'(int_flags);
    end else begin
      for (int i = 0; i < NUM_EP; i++) begin
        if (rd_idx == EP_W'(i)) begin
          case (rd_grp)
            GRP_CSR: rd_data = csr_rd[i];
            GRP_CAR: rd_data = car_rd[i];
            GRP_CNT: rd_data = cnt_rd[i];
            default: rd_data = '0;
          endcase
        end
      end
    end
  end

  assign irq   = |int_flags;
  assign stage = stage_q;

endmodule

// File: rtl/usb_ep_handshake_chk.sv
module usb_ep_handshake_chk #(
  parameter int NUM_EP = 3,
  parameter int EP_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_valid,
  input logic [EP_W-1:0]   ev_ep,
  input logic [NUM_EP-1:0] acc_xfer,
  input logic              acc_setup0,
  input logic [NUM_EP-1:0] int_flags,
  input logic [NUM_EP-1:0] tog_vec,
  input logic [NUM_EP-1:0] en_vec,
  input logic [2:0]        stage
);

  AST_SETUP_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_setup0 |=> (stage == 3'd1)); // R2

  AST_STAGE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    stage != 3'd7); // R10

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
      acc_xfer[i] |=> (tog_vec[i] != $past(tog_vec[i]))); // R5

    AST_INT_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
      acc_xfer[i] |=> int_flags[i]); // R8

    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && (ev_ep == EP_W'(i)) && !en_vec[i])
        |=> ($stable(tog_vec[i]) && !$rose(int_flags[i]))); // R9
  end

endmodule

bind usb_ep_handshake usb_ep_handshake_chk #(
  .NUM_EP (NUM_EP),
  .EP_W   (EP_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ev_valid   (ev_valid),
  .ev_ep      (ev_ep),
  .acc_xfer   (acc_xfer),
  .acc_setup0 (acc_setup0),
  .int_flags  (int_flags),
  .tog_vec    (tog_vec),
  .en_vec     (en_vec),
  .stage      (stage)
);

// File: tb/usb_ep_handshake_bench.sv
`timescale 1ns/10ps
module usb_ep_handshake_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_valid = 1'b0;
  logic [1:0] ev_ep = '0;
  logic [1:0] ev_kind = '0;
  logic [4:0] ev_len = '0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       irq;
  logic [2:0] stage;

  int checks = 0;
  int errors = 0;

  // Bench model of every readable bit.
  logic       m_txd [3], m_rxo [3], m_rxs [3], m_sts [3], m_tog [3];
  logic       m_txr [3], m_fst [3], m_den [3], m_en [3], m_int [3];
  logic [4:0] m_cnt [3];
  logic [2:0] m_stage;

  always #4 clk = ~clk;

  usb_ep_handshake u_usb_ep_handshake (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ep(ev_ep),
    .ev_kind(ev_kind), .ev_len(ev_len), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq),
    .stage(stage)
  );

  function automatic logic [2:0] stage_rule(logic [2:0] s, logic su, logic o, logic i, logic d);
    if (su) return 3'd1;
    case (s)
      3'd1: return o ? 3'd2 : (i ? 3'd3 : (d ? 3'd6 : 3'd1));
      3'd2: return (!o && d) ? 3'd4 : 3'd2;
      3'd3: return (!i && d) ? 3'd5 : 3'd3;
      3'd4: return i ? 3'd0 : 3'd4;
      3'd5: return o ? 3'd0 : 3'd5;
      3'd6: return i ? 3'd0 : 3'd6;
      default: return s;
    endcase
  endfunction

  function automatic logic [7:0] expect_rd(logic [3:0] a);
    int g = a[3:2];
    int x = a[1:0];
    if (g == 3) return (x == 0) ? {5'b0, m_int[2], m_int[1], m_int[0]} : 8'h00;
    if (x == 3) return 8'h00;
    case (g)
      0: return {3'b0, m_tog[x], m_sts[x], m_rxs[x], m_rxo[x], m_txd[x]};
      1: return {m_en[x], m_den[x], m_fst[x], m_txr[x], 4'b0};
      default: return {3'b0, m_cnt[x]};
    endcase
  endfunction

  task automatic model_reset();
    for (int e = 0; e < 3; e++) begin
      m_txd[e] = 0; m_rxo[e] = 0; m_rxs[e] = 0; m_sts[e] = 0; m_tog[e] = 0;
      m_txr[e] = 0; m_fst[e] = 0; m_den[e] = 0; m_en[e] = 0; m_int[e] = 0;
      m_cnt[e] = 0;
    end
    m_stage = 0;
  endtask

  task automatic model_step(logic ev, logic [1:0] ep, logic [1:0] k, logic [4:0] len,
                            logic we, logic [3:0] wa, logic [7:0] wd);
    logic as [3], ao [3], ai [3], ast [3];
    for (int e = 0; e < 3; e++) begin
      logic hit;
      hit    = ev && (ep == 2'(e));
      as[e]  = hit && k == 0 && m_en[e] && e == 0;
      ao[e]  = hit && k == 1 && m_en[e] && !m_fst[e];
      ai[e]  = hit && k == 2 && m_en[e] && !m_fst[e] && m_txr[e];
      ast[e] = hit && k == 3 && m_en[e] && m_fst[e];
    end
    m_stage = stage_rule(m_stage, as[0], ao[0], ai[0], m_den[0]);
    for (int e = 0; e < 3; e++) begin
      if (we && wa[3:2] == 1 && wa[1:0] == 2'(e)) begin
        if (wd[0]) m_txd[e] = 0;
        if (wd[1]) m_rxo[e] = 0;
        if (wd[2]) m_rxs[e] = 0;
        if (wd[3]) m_sts[e] = 0;
        m_txr[e] = wd[4]; m_fst[e] = wd[5]; m_den[e] = wd[6]; m_en[e] = wd[7];
      end
      if (we && wa == 4'd13 && wd[e]) m_int[e] = 0;
      if (as[e]) begin m_rxs[e] = 1; m_cnt[e] = len; m_fst[e] = 0; m_den[e] = 0; end
      if (ao[e]) begin m_rxo[e] = 1; m_cnt[e] = len; end
      if (ai[e]) begin m_txr[e] = 0; m_txd[e] = 1; end
      if (ast[e]) m_sts[e] = 1;
      if (as[e] || ao[e] || ai[e]) begin m_tog[e] = ~m_tog[e]; m_int[e] = 1; end
    end
  endtask

  task automatic check(string req, string what, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic check_all(string req);
    for (int a = 0; a < 16; a++) begin
      rd_addr = 4'(a);
      #0.15;
      check(req, $sformatf("rd[%0d]", a), rd_data, expect_rd(4'(a)));
    end
    check(req, "stage", {5'b0, stage}, {5'b0, m_stage});
    check(req, "irq", {7'b0, irq}, {7'b0, (m_int[0] | m_int[1] | m_int[2])});
  endtask

  task automatic op(string req, logic ev, logic [1:0] ep, logic [1:0] k, logic [4:0] len,
                    logic we, logic [3:0] wa, logic [7:0] wd);
    @(negedge clk);
    ev_valid = ev; ev_ep = ep; ev_kind = k; ev_len = len;
    wr_en = we; wr_addr = wa; wr_data = wd;
    model_step(ev, ep, k, len, we, wa, wd);
    @(posedge clk);
    #1;
    ev_valid = 0; wr_en = 0;
    check_all(req);
  endtask

  task automatic evt(string req, logic [1:0] ep, logic [1:0] k, logic [4:0] len);
    op(req, 1'b1, ep, k, len, 1'b0, 4'd0, 8'd0);
  endtask

  task automatic wr(string req, logic [3:0] wa, logic [7:0] wd);
    op(req, 1'b0, 2'd0, 2'd0, 5'd0, 1'b1, wa, wd);
  endtask

  task automatic peek(string req, logic [3:0] a, logic [7:0] exp);
    rd_addr = a;
    #0.15;
    check(req, $sformatf("literal rd[%0d]", a), rd_data, exp);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check_all("R11");
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check_all("R11");

    // R9: disabled endpoints ignore everything
    evt("R9", 2'd0, 2'd0, 5'd8);
    evt("R9", 2'd1, 2'd1, 5'd4);
    peek("R9", 4'd0, 8'h00);

    // R2 / R5 / R8: setup on enabled control endpoint
    wr("R7", 4'd4, 8'h80);
    evt("R2", 2'd0, 2'd0, 5'd8);
    peek("R2", 4'd0, 8'h14);
    peek("R2", 4'd8, 8'h08);
    peek("R8", 4'd12, 8'h01);
    check("R10", "stage after setup", {5'b0, stage}, 8'd1);

    // R10 control write: OUT, data-end, status IN
    evt("R3", 2'd0, 2'd1, 5'd5);
    check("R10", "write data", {5'b0, stage}, 8'd2);
    wr("R7", 4'd4, 8'hC6);
    op("R10", 1'b0, 2'd0, 2'd0, 5'd0, 1'b0, 4'd0, 8'd0);
    check("R10", "write status", {5'b0, stage}, 8'd4);
    wr("R4", 4'd4, 8'hD0);
    evt("R4", 2'd0, 2'd2, 5'd0);
    check("R10", "back to idle", {5'b0, stage}, 8'd0);
    peek("R4", 4'd4, 8'hC0);

    // R7: same-cycle ack and OUT event, event wins
    op("R7", 1'b1, 2'd0, 2'd1, 5'd3, 1'b1, 4'd4, 8'h83);
    peek("R7", 4'd0, 8'h02);

    // R6: stall handling and status writes ignored
    wr("R6", 4'd4, 8'hA0);
    evt("R6", 2'd0, 2'd1, 5'd9);
    evt("R6", 2'd0, 2'd3, 5'd0);
    wr("R6", 4'd0, 8'hFF);
    peek("R6", 4'd0, 8'h0A);
    evt("R2", 2'd0, 2'd0, 5'd8);
    peek("R2", 4'd4, 8'h80);

    // R10 control read and no-data flows
    wr("R4", 4'd4, 8'h97);
    evt("R10", 2'd0, 2'd2, 5'd0);
    wr("R10", 4'd4, 8'hC0);
    op("R10", 1'b0, 2'd0, 2'd0, 5'd0, 1'b0, 4'd0, 8'd0);
    check("R10", "read status", {5'b0, stage}, 8'd5);
    evt("R10", 2'd0, 2'd1, 5'd0);
    evt("R10", 2'd0, 2'd0, 5'd8);
    wr("R10", 4'd4, 8'hC0);
    op("R10", 1'b0, 2'd0, 2'd0, 5'd0, 1'b0, 4'd0, 8'd0);
    check("R10", "no-data status", {5'b0, stage}, 8'd6);
    wr("R10", 4'd4, 8'hD0);
    evt("R10", 2'd0, 2'd2, 5'd0);

    // R4: IN without tx-ready ignored; R2: SETUP on data endpoint ignored
    wr("R4", 4'd5, 8'h80);
    evt("R4", 2'd1, 2'd2, 5'd0);
    evt("R2", 2'd1, 2'd0, 5'd8);
    peek("R4", 4'd1, 8'h00);

    // R8: acknowledge, and same-cycle set wins
    wr("R8", 4'd13, 8'h07);
    peek("R8", 4'd12, 8'h00);
    op("R8", 1'b1, 2'd1, 2'd1, 5'd2, 1'b1, 4'd13, 8'h02);
    peek("R8", 4'd12, 8'h02);

    // R1: unused addresses
    wr("R1", 4'd12, 8'hFF);
    peek("R1", 4'd3, 8'h00);
    peek("R1", 4'd13, 8'h00);
    peek("R1", 4'd15, 8'h00);

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      logic ev, we;
      logic [3:0] wa;
      logic [7:0] wd;
      ev = ($urandom % 2) == 0;
      we = ($urandom % 5) < 2;
      case ($urandom % 4)
        0: wa = 4'd13;
        1: wa = 4'($urandom % 16);
        default: wa = {2'b01, 2'($urandom % 3)};
      endcase
      wd = 8'($urandom);
      if (($urandom % 4) != 0) wd[7] = 1'b1;
      if (($urandom % 3) != 0) wd[5] = 1'b0;
      op((n % 2 == 0) ? "R3" : "R5", ev, 2'($urandom % 4), 2'($urandom % 4),
         5'($urandom), we, wa, wd);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule